// File: doc/BRIEF.md
# Starvation Request Table

This block keeps, for each cache line that currently has outstanding starvation requests, the set of requesters that are starving on it. It serves a token-based coherence controller. Alongside the starving set, each live entry holds two more requester bitmaps. One records which starvers asked for write access. The other holds a frozen snapshot of the starvers taken by a mark command. A non-empty snapshot stops any new requester from starting a starvation request on that line until every snapshotted requester has released it.

A requester is named by a group number (its machine type) and an index inside that group. Inside the table it maps to bit `type*N_PER_TYPE + idx` of each bitmap. Commands arrive on one command lane, one per clock: lock, unlock or mark. Their effect is visible on the query port from the next cycle. The query port is purely combinational over the stored state. For an address and a requester it returns:
- whether that requester may issue a starvation request;
- the winning starver and its access type;
- the starving and read-starving counts.

The entries are searched in parallel. Protocol violations and capacity exhaustion are reported as one-cycle error pulses, and the offending command is dropped.

Top module: `starve_table`

## Requirements
- R1: After reset the table is empty: any query sees `qry_hit`=0, `qry_may_issue`=1, both counts 0, `qry_top_vld`=0, and all error outputs 0.
- R2: `cmd_op`=2'b01 (lock) on a line with no entry allocates one. It then adds the requester to the starving set, and when `cmd_wr`=1 also to the write set. The effect is visible on the query port in the cycle after the command edge.
- R3: A lock by a requester already starving on that line raises `err_dup_lock` for one cycle after the edge and leaves the entry unchanged, write set included.
- R4: `cmd_op`=2'b10 (unlock) removes the requester from the starving, marked and write sets, and frees the entry when no starver remains. An unlock by a requester that is not starving, or on a line with no entry, raises `err_bad_unlock` and changes nothing.
- R5: `qry_may_issue` is 1 when the line has no entry. It is 0 when the queried requester is itself starving there. Otherwise it is 1 only when the marked set is empty.
- R6: The winning starver is the lowest set bit of the starving set: lowest group first, then lowest index in that group. It is output as `qry_top_type`/`qry_top_idx`, and `qry_top_wr`=1 when that requester is in the write set.
- R7: `cmd_op`=2'b11 (mark) copies the starving set into the marked set when an entry exists and the marked set is empty. If the marked set is not empty, the mark raises `err_mark_busy` and changes nothing. With no entry, a mark has no effect and raises no error.
- R8: `qry_starve_cnt` is the number of starvers on the line. `qry_read_cnt` is the number of starvers not in the write set. Both are 0 when no entry exists.
- R9: A lock that needs a new entry while all `N_ENTRIES` are live raises `err_overflow` and is dropped.
- R10: A command whose address has any of the low `LINE_OFF_W` bits set raises `err_misalign` and is dropped.
- R11: With `qry_top_req`=1 on a line with no entry, `qry_top_err`=1 and `qry_top_vld`=0.
- R12: Entries for different lines are independent: each line's counts and winner reflect only its own commands, and freeing one line's entry leaves the others intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 mark |
| cmd_addr | input | ADDR_W | Line address of the command |
| cmd_type | input | TYPE_W | Requester group of the command |
| cmd_idx | input | IDX_W | Requester index of the command |
| cmd_wr | input | 1 | Lock is for write access |
| qry_addr | input | ADDR_W | Line address being queried |
| qry_type | input | TYPE_W | Requester group asking to issue |
| qry_idx | input | IDX_W | Requester index asking to issue |
| qry_top_req | input | 1 | Winner lookup is being requested |
| qry_hit | output | 1 | Queried line has a live entry |
| qry_may_issue | output | 1 | Queried requester may issue a starvation request |
| qry_top_vld | output | 1 | Winner outputs are valid |
| qry_top_type | output | TYPE_W | Group of the winning starver |
| qry_top_idx | output | IDX_W | Index of the winning starver |
| qry_top_wr | output | 1 | Winning starver wants write access |
| qry_top_err | output | 1 | Winner requested on a line with no entry |
| qry_starve_cnt | output | CNT_W | Number of starvers on the line |
| qry_read_cnt | output | CNT_W | Number of read starvers on the line |
| err_dup_lock | output | 1 | Previous command was a repeated lock |
| err_bad_unlock | output | 1 | Previous command unlocked a non-starver |
| err_mark_busy | output | 1 | Previous mark found a snapshot already held |
| err_overflow | output | 1 | Previous lock found the table full |
| err_misalign | output | 1 | Previous command address was not line aligned |

## Verification
Several properties are checked on every cycle by the assertions:
- the marked and write sets of every entry stay within its starving set;
- a live entry never has an empty starving set;
- no two entries hold the same line;
- the reported winner has no lower starving bit below it;
- the read count never exceeds the starving count;
- at most one error fires per cycle;
- overflow only fires with every entry live, and dropped commands leave the live-entry vector unchanged.

Only the directed scenarios can show the sequence-level behaviour:
- the snapshot blocking new issuers until the last marked starver leaves;
- the write flag being cleared with its requester;
- an entry being freed and reused for a new line;
- the exact winner and counts after each mix of reads and writes.

// File: rtl/starve_tbl_pkg.sv
package starve_tbl_pkg;

   // Command encoding on the single command lane
   typedef enum logic [1:0] {
      OP_NOP    = 2'b00,
      OP_LOCK   = 2'b01,
      OP_UNLOCK = 2'b10,
      OP_MARK   = 2'b11
   } stt_op_e;

   // One-cycle error pulses, at most one per command
   typedef struct packed {
      logic dup_lock;
      logic bad_unlock;
      logic mark_busy;
      logic overflow;
      logic misalign;
   } stt_err_t;

endpackage

// File: rtl/stt_entry.sv
module stt_entry #(
   parameter int ADDR_W = 16,
   parameter int NREQ   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              lk_set,
   input  logic              unlk,
   input  logic              mk,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [NREQ-1:0]   req,
   input  logic              wr_req,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic [NREQ-1:0]   starve,
   output logic [NREQ-1:0]   marked,
   output logic [NREQ-1:0]   wrset
);

   logic [NREQ-1:0] starve_left;

   always_comb begin
      starve_left = starve & ~req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         addr   <= '0;
         starve <= '0;
         marked <= '0;
         wrset  <= '0;
      end else if (alloc) begin
         valid  <= 1'b1;
         addr   <= new_addr;
         starve <= req;
         marked <= '0;
         wrset  <= wr_req ? req : '0;
      end else if (lk_set) begin
         starve <= starve | req;
         if (wr_req) begin
            wrset <= wrset | req;
         end
      end else if (unlk) begin
         if (starve_left == '0) begin
            valid  <= 1'b0;
            starve <= '0;
            marked <= '0;
            wrset  <= '0;
         end else begin
            starve <= starve_left;
            marked <= marked & ~req;
            wrset  <= wrset & ~req;
         end
      end else if (mk) begin
         marked <= starve;
      end
   end

   AST_WR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (wrset & ~starve) == '0);  // R2
   AST_MARK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (marked & ~starve) == '0);  // R7
   AST_LIVE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (starve != '0));  // R4
   AST_FREE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (starve == '0 && marked == '0 && wrset == '0));  // R4

endmodule

// File: rtl/stt_prio.sv
module stt_prio #(
   parameter int N_TYPES    = 2,
   parameter int N_PER_TYPE = 4,
   parameter int TYPE_W     = 1,
   parameter int IDX_W      = 2
) (
   input  logic [N_TYPES*N_PER_TYPE-1:0] vec,
   output logic                          found,
   output logic [N_TYPES*N_PER_TYPE-1:0] onehot,
   output logic [TYPE_W-1:0]             grp,
   output logic [IDX_W-1:0]              idx
);

   localparam int NREQ = N_TYPES * N_PER_TYPE;

   int pos;

   // Lowest set bit wins: group order first, then index within group
   always_comb begin
      pos    = 0;
      found  = 1'b0;
      onehot = '0;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (vec[i]) begin
            pos   = i;
            found = 1'b1;
         end
      end
      if (found) begin
         onehot[pos] = 1'b1;
      end
   end

   generate
      if (N_TYPES == 1) begin : g_single_grp
         assign grp = '0;
         assign idx = IDX_W'(pos);
      end else if (N_PER_TYPE == 1) begin : g_single_idx
         assign grp = TYPE_W'(pos);
         assign idx = '0;
      end else begin : g_split
         assign grp = TYPE_W'(pos / N_PER_TYPE);
         assign idx = IDX_W'(pos % N_PER_TYPE);
      end
   endgenerate

endmodule

// File: rtl/stt_popcnt.sv
module stt_popcnt #(
   parameter int W  = 8,
   parameter int CW = 4
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   generate
      if (W == 1) begin : g_one
         assign cnt = CW'(vec);
      end else begin : g_sum
         always_comb begin
            cnt = '0;
            for (int i = 0; i < W; i++) begin
               cnt = cnt + CW'(vec[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/starve_table.sv
module starve_table
   import starve_tbl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_OFF_W = 6,
   parameter int N_TYPES    = 2,
   parameter int N_PER_TYPE = 4,
   parameter int N_ENTRIES  = 4,
   localparam int NREQ      = N_TYPES * N_PER_TYPE,
   localparam int TYPE_W    = (N_TYPES > 1) ? $clog2(N_TYPES) : 1,
   localparam int IDX_W     = (N_PER_TYPE > 1) ? $clog2(N_PER_TYPE) : 1,
   localparam int CNT_W     = $clog2(NREQ + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [TYPE_W-1:0] cmd_type,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] qry_addr,
   input  logic [TYPE_W-1:0] qry_type,
   input  logic [IDX_W-1:0]  qry_idx,
   input  logic              qry_top_req,
   output logic              qry_hit,
   output logic              qry_may_issue,
   output logic              qry_top_vld,
   output logic [TYPE_W-1:0] qry_top_type,
   output logic [IDX_W-1:0]  qry_top_idx,
   output logic              qry_top_wr,
   output logic              qry_top_err,
   output logic [CNT_W-1:0]  qry_starve_cnt,
   output logic [CNT_W-1:0]  qry_read_cnt,
   output logic              err_dup_lock,
   output logic              err_bad_unlock,
   output logic              err_mark_busy,
   output logic              err_overflow,
   output logic              err_misalign
);

   // Elaboration-time parameter checks
   generate
      if (LINE_OFF_W < 1 || LINE_OFF_W >= ADDR_W) begin : g_bad_off
         $error("starve_table: LINE_OFF_W must lie in 1..ADDR_W-1");
      end
      if (N_TYPES < 1 || N_PER_TYPE < 1) begin : g_bad_req
         $error("starve_table: requester space must be non-empty");
      end
      if (N_ENTRIES < 1) begin : g_bad_ent
         $error("starve_table: N_ENTRIES must be at least 1");
      end
   endgenerate

   // Requester id to bitmap position
   function automatic logic [NREQ-1:0] req_bit(input logic [TYPE_W-1:0] t,
                                               input logic [IDX_W-1:0]  i);
      logic [NREQ-1:0] v;
      int p;
      v = '0;
      if (int'(t) < N_TYPES && int'(i) < N_PER_TYPE) begin
         p    = int'(t) * N_PER_TYPE + int'(i);
         v[p] = 1'b1;
      end
      return v;
   endfunction

   // Entry array
   logic [N_ENTRIES-1:0] ev;
   logic [N_ENTRIES-1:0] e_alloc, e_lk, e_unlk, e_mk;
   logic [ADDR_W-1:0]    ea [N_ENTRIES];
   logic [NREQ-1:0]      es [N_ENTRIES];
   logic [NREQ-1:0]      em [N_ENTRIES];
   logic [NREQ-1:0]      ew [N_ENTRIES];
   logic [NREQ-1:0]      c_req;

   generate
      for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
         stt_entry #(
            .ADDR_W (ADDR_W),
            .NREQ   (NREQ)
         ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (e_alloc[g]),
            .lk_set   (e_lk[g]),
            .unlk     (e_unlk[g]),
            .mk       (e_mk[g]),
            .new_addr (cmd_addr),
            .req      (c_req),
            .wr_req   (cmd_wr),
            .valid    (ev[g]),
            .addr     (ea[g]),
            .starve   (es[g]),
            .marked   (em[g]),
            .wrset    (ew[g])
         );
      end
   endgenerate

   // Parallel lookup for the command lane and the query port
   logic [N_ENTRIES-1:0] c_hitv, q_hitv, free_oh;
   logic [NREQ-1:0]      c_s, c_m, q_s, q_m, q_w;
   logic                 c_hit, free_any;

   always_comb begin
      c_hitv   = '0;
      q_hitv   = '0;
      c_s      = '0;
      c_m      = '0;
      q_s      = '0;
      q_m      = '0;
      q_w      = '0;
      free_oh  = '0;
      free_any = 1'b0;
      for (int e = 0; e < N_ENTRIES; e++) begin
         c_hitv[e] = ev[e] && (ea[e] == cmd_addr);
         q_hitv[e] = ev[e] && (ea[e] == qry_addr);
         if (c_hitv[e]) begin
            c_s = c_s | es[e];
            c_m = c_m | em[e];
         end
         if (q_hitv[e]) begin
            q_s = q_s | es[e];
            q_m = q_m | em[e];
            q_w = q_w | ew[e];
         end
      end
      for (int e = N_ENTRIES - 1; e >= 0; e--) begin
         if (!ev[e]) begin
            free_oh    = '0;
            free_oh[e] = 1'b1;
            free_any   = 1'b1;
         end
      end
      c_hit = |c_hitv;
   end

   // Command decode
   stt_op_e  op;
   stt_err_t nx_err, err_q;
   logic     aligned, c_in_set;

   always_comb begin
      op       = stt_op_e'(cmd_op);
      c_req    = req_bit(cmd_type, cmd_idx);
      aligned  = (cmd_addr[LINE_OFF_W-1:0] == '0);
      c_in_set = c_hit && ((c_s & c_req) != '0);
      e_alloc  = '0;
      e_lk     = '0;
      e_unlk   = '0;
      e_mk     = '0;
      nx_err   = '0;
      if (op != OP_NOP && !aligned) begin
         nx_err.misalign = 1'b1;
      end else begin
         case (op)
            OP_LOCK: begin
               if (c_req != '0) begin
                  if (c_in_set) begin
                     nx_err.dup_lock = 1'b1;
                  end else if (c_hit) begin
                     e_lk = c_hitv;
                  end else if (free_any) begin
                     e_alloc = free_oh;
                  end else begin
                     nx_err.overflow = 1'b1;
                  end
               end
            end
            OP_UNLOCK: begin
               if (!c_in_set) begin
                  nx_err.bad_unlock = 1'b1;
               end else begin
                  e_unlk = c_hitv;
               end
            end
            OP_MARK: begin
               if (c_hit) begin
                  if (c_m != '0) begin
                     nx_err.mark_busy = 1'b1;
                  end else begin
                     e_mk = c_hitv;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= '0;
      end else begin
         err_q <= nx_err;
      end
   end

   assign err_dup_lock   = err_q.dup_lock;
   assign err_bad_unlock = err_q.bad_unlock;
   assign err_mark_busy  = err_q.mark_busy;
   assign err_overflow   = err_q.overflow;
   assign err_misalign   = err_q.misalign;

   // Query port
   logic [NREQ-1:0] q_req, top_oh;
   logic            top_found;

   always_comb begin
      q_req   = req_bit(qry_type, qry_idx);
      qry_hit = |q_hitv;
      if (!qry_hit) begin
         qry_may_issue = 1'b1;
      end else if ((q_s & q_req) != '0) begin
         qry_may_issue = 1'b0;
      end else begin
         qry_may_issue = (q_m == '0);
      end
   end

   stt_prio #(
      .N_TYPES    (N_TYPES),
      .N_PER_TYPE (N_PER_TYPE),
      .TYPE_W     (TYPE_W),
      .IDX_W      (IDX_W)
   ) u_prio (
      .vec    (q_s),
      .found  (top_found),
      .onehot (top_oh),
      .grp    (qry_top_type),
      .idx    (qry_top_idx)
   );

   assign qry_top_vld = qry_hit && top_found;
   assign qry_top_wr  = qry_top_vld && ((q_w & top_oh) != '0);
   assign qry_top_err = qry_top_req && !qry_hit;

   stt_popcnt #(.W(NREQ), .CW(CNT_W)) u_cnt_all (
      .vec (q_s),
      .cnt (qry_starve_cnt)
   );

   stt_popcnt #(.W(NREQ), .CW(CNT_W)) u_cnt_rd (
      .vec (q_s & ~q_w),
      .cnt (qry_read_cnt)
   );

   // Assertions
   AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(c_hitv));  // R12
   AST_TOP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      qry_top_vld |-> ((q_s & (top_oh - 1'b1)) == '0 && (q_s & top_oh) != '0));  // R6
   AST_HIT_HAS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      qry_hit |-> top_found);  // R11
   AST_READ_LE: assert property (@(posedge clk) disable iff (!rst_n)
      qry_read_cnt <= qry_starve_cnt);  // R8
   AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(err_q) <= 1);  // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> ($past(&ev) && $stable(ev)));  // R9
   AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      err_misalign |-> $stable(ev));  // R10
   AST_EMPTY_MAY: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_hit |-> (qry_may_issue && qry_starve_cnt == '0));  // R5

endmodule

// File: tb/starve_table_bench.sv
module starve_table_bench;

   localparam int ADDR_W = 16;
   localparam int TW     = 1;
   localparam int IW     = 2;
   localparam int CW     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cmd_op = 2'b00;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [TW-1:0]     cmd_type = '0;
   logic [IW-1:0]     cmd_idx = '0;
   logic              cmd_wr = 1'b0;
   logic [ADDR_W-1:0] qry_addr = '0;
   logic [TW-1:0]     qry_type = '0;
   logic [IW-1:0]     qry_idx = '0;
   logic              qry_top_req = 1'b0;
   logic              qry_hit, qry_may_issue, qry_top_vld, qry_top_wr, qry_top_err;
   logic [TW-1:0]     qry_top_type;
   logic [IW-1:0]     qry_top_idx;
   logic [CW-1:0]     qry_starve_cnt, qry_read_cnt;
   logic              err_dup_lock, err_bad_unlock, err_mark_busy, err_overflow, err_misalign;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [1:0] LOCK = 2'b01, UNLOCK = 2'b10, MARK = 2'b11;
   localparam logic [ADDR_W-1:0] A = 16'h0040, B = 16'h0080, C = 16'h00C0,
                                 D = 16'h0100, E = 16'h0140;

   always #4 clk = ~clk;

   starve_table u_starve_table (
      .clk(clk), .rst_n(rst_n),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_type(cmd_type),
      .cmd_idx(cmd_idx), .cmd_wr(cmd_wr),
      .qry_addr(qry_addr), .qry_type(qry_type), .qry_idx(qry_idx),
      .qry_top_req(qry_top_req),
      .qry_hit(qry_hit), .qry_may_issue(qry_may_issue), .qry_top_vld(qry_top_vld),
      .qry_top_type(qry_top_type), .qry_top_idx(qry_top_idx), .qry_top_wr(qry_top_wr),
      .qry_top_err(qry_top_err), .qry_starve_cnt(qry_starve_cnt), .qry_read_cnt(qry_read_cnt),
      .err_dup_lock(err_dup_lock), .err_bad_unlock(err_bad_unlock),
      .err_mark_busy(err_mark_busy), .err_overflow(err_overflow), .err_misalign(err_misalign)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Apply one command; on return the state and error pulses are visible
   task automatic do_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input int t, input int i, input logic w);
      @(negedge clk);
      cmd_op   = op;
      cmd_addr = a;
      cmd_type = TW'(t);
      cmd_idx  = IW'(i);
      cmd_wr   = w;
      @(negedge clk);
      cmd_op   = 2'b00;
      cmd_wr   = 1'b0;
   endtask

   task automatic errs(input string tag, input int exp_vec);
      check(tag, int'({err_dup_lock, err_bad_unlock, err_mark_busy, err_overflow, err_misalign}),
            exp_vec);
   endtask

   task automatic query(input logic [ADDR_W-1:0] a, input int t, input int i);
      qry_addr = a;
      qry_type = TW'(t);
      qry_idx  = IW'(i);
      #1;
   endtask

   // R1
   task automatic t_reset();
      query(A, 0, 0);
      check("R1 hit", int'(qry_hit), 0);
      check("R1 may", int'(qry_may_issue), 1);
      check("R1 cnt", int'(qry_starve_cnt), 0);
      check("R1 rcnt", int'(qry_read_cnt), 0);
      check("R1 topvld", int'(qry_top_vld), 0);
      errs("R1 errs", 0);
   endtask

   // R2 R6 R8
   task automatic t_lock();
      do_cmd(LOCK, A, 1, 2, 1'b1);
      errs("R2 errs", 0);
      query(A, 0, 0);
      check("R2 hit", int'(qry_hit), 1);
      check("R2 cnt", int'(qry_starve_cnt), 1);
      check("R2 rcnt", int'(qry_read_cnt), 0);
      check("R2 topwr", int'(qry_top_wr), 1);
      do_cmd(LOCK, A, 0, 3, 1'b0);
      query(A, 0, 0);
      check("R8 cnt", int'(qry_starve_cnt), 2);
      check("R8 rcnt", int'(qry_read_cnt), 1);
      check("R6 toptype", int'(qry_top_type), 0);
      check("R6 topidx", int'(qry_top_idx), 3);
      check("R6 topwr", int'(qry_top_wr), 0);
      check("R5 may nomark", int'(qry_may_issue), 1);
   endtask

   // R3
   task automatic t_dup();
      do_cmd(LOCK, A, 1, 2, 1'b0);
      errs("R3 errs", 16);
      query(A, 0, 0);
      check("R3 cnt", int'(qry_starve_cnt), 2);
      check("R3 rcnt", int'(qry_read_cnt), 1);
   endtask

   // R6 R5
   task automatic t_prio();
      do_cmd(LOCK, A, 0, 1, 1'b1);
      query(A, 1, 3);
      check("R6 toptype2", int'(qry_top_type), 0);
      check("R6 topidx2", int'(qry_top_idx), 1);
      check("R6 topwr2", int'(qry_top_wr), 1);
      check("R8 cnt3", int'(qry_starve_cnt), 3);
      check("R8 rcnt3", int'(qry_read_cnt), 1);
      check("R5 may other", int'(qry_may_issue), 1);
      query(A, 0, 3);
      check("R5 may self", int'(qry_may_issue), 0);
   endtask

   // R7
   task automatic t_mark();
      do_cmd(MARK, A, 0, 0, 1'b0);
      errs("R7 errs", 0);
      query(A, 1, 3);
      check("R7 may blocked", int'(qry_may_issue), 0);
      do_cmd(MARK, A, 0, 0, 1'b0);
      errs("R7 busy", 4);
      do_cmd(MARK, B, 0, 0, 1'b0);
      errs("R7 noentry errs", 0);
      query(B, 0, 0);
      check("R7 noentry hit", int'(qry_hit), 0);
      do_cmd(LOCK, A, 1, 3, 1'b0);
      query(A, 0, 0);
      check("R7 cnt4", int'(qry_starve_cnt), 4);
      check("R7 may still", int'(qry_may_issue), 0);
   endtask

   // R4 R5
   task automatic t_unlock();
      // A starving: 0/1 w, 0/3, 1/2 w, 1/3 ; marked: 0/1, 0/3, 1/2
      do_cmd(UNLOCK, A, 0, 1, 1'b0);
      errs("R4 errs", 0);
      query(A, 0, 0);
      check("R4 topidx", int'(qry_top_idx), 3);
      check("R4 cnt", int'(qry_starve_cnt), 3);
      check("R4 rcnt", int'(qry_read_cnt), 2);
      check("R4 may", int'(qry_may_issue), 0);
      do_cmd(LOCK, A, 0, 1, 1'b0);
      query(A, 0, 0);
      check("R4 wr cleared", int'(qry_top_wr), 0);
      check("R4 rcnt2", int'(qry_read_cnt), 3);
      do_cmd(UNLOCK, A, 0, 1, 1'b0);
      do_cmd(UNLOCK, A, 0, 3, 1'b0);
      do_cmd(UNLOCK, A, 1, 2, 1'b0);
      query(A, 0, 0);
      check("R5 may unmarked", int'(qry_may_issue), 1);
      check("R4 cnt1", int'(qry_starve_cnt), 1);
      do_cmd(UNLOCK, A, 0, 0, 1'b0);
      errs("R4 bad", 8);
      do_cmd(UNLOCK, A, 1, 3, 1'b0);
      query(A, 0, 0);
      check("R4 freed", int'(qry_hit), 0);
      do_cmd(UNLOCK, A, 1, 3, 1'b0);
      errs("R4 bad noentry", 8);
   endtask

   // R9 R12
   task automatic t_overflow();
      do_cmd(LOCK, A, 0, 0, 1'b0);
      do_cmd(LOCK, B, 0, 1, 1'b1);
      do_cmd(LOCK, C, 1, 0, 1'b0);
      do_cmd(LOCK, D, 1, 1, 1'b0);
      query(B, 0, 0);
      check("R12 B cnt", int'(qry_starve_cnt), 1);
      check("R12 B rcnt", int'(qry_read_cnt), 0);
      query(C, 0, 0);
      check("R12 C top", int'(qry_top_type), 1);
      check("R12 C rcnt", int'(qry_read_cnt), 1);
      do_cmd(LOCK, E, 0, 2, 1'b0);
      errs("R9 overflow", 2);
      query(E, 0, 0);
      check("R9 dropped", int'(qry_hit), 0);
      do_cmd(UNLOCK, D, 1, 1, 1'b0);
      query(C, 0, 0);
      check("R12 C kept", int'(qry_hit), 1);
      do_cmd(LOCK, E, 0, 2, 1'b0);
      errs("R9 reuse errs", 0);
      query(E, 0, 0);
      check("R9 reuse hit", int'(qry_hit), 1);
      check("R9 reuse idx", int'(qry_top_idx), 2);
   endtask

   // R10
   task automatic t_misalign();
      do_cmd(LOCK, 16'h0041, 0, 3, 1'b0);
      errs("R10 misalign", 1);
      query(A, 0, 0);
      check("R10 A cnt", int'(qry_starve_cnt), 1);
      do_cmd(UNLOCK, 16'h0060, 0, 0, 1'b0);
      errs("R10 misalign unlock", 1);
      query(A, 0, 0);
      check("R10 A kept", int'(qry_hit), 1);
   endtask

   // R11
   task automatic t_top_err();
      qry_top_req = 1'b1;
      query(D, 0, 0);
      check("R11 err", int'(qry_top_err), 1);
      check("R11 vld", int'(qry_top_vld), 0);
      query(A, 0, 0);
      check("R11 noerr", int'(qry_top_err), 0);
      check("R11 vld hit", int'(qry_top_vld), 1);
      qry_top_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_dup();
      t_prio();
      t_mark();
      t_unlock();
      t_overflow();
      t_misalign();
      t_top_err();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule